// File: doc/BRIEF.md
# Two-Stage Pipelined Data Cache

This block is the data cache for a long processor pipeline. The lookup takes two memory stages. In the first stage, the block reads the tag, valid and data arrays, which are synchronous on-chip RAM, and checks that the store queue has room. In the second stage, the block compares the tags, delivers load data on a hit, or stalls the pipeline on a miss. The cache has two ways. Each line holds four 32-bit words, and there are 64 sets. A line is refilled over a plain word-addressed memory port that uses a request/acknowledge handshake.

Stores are write-through with no allocation on a miss. A store that hits also updates the cached word. Every store is placed in a four-entry queue, and the queue drains to the same memory port. A load miss first waits for the queue to empty, then reads the line and fills it into the chosen way. When both ways of a set hold data, the victim way is picked by a free-running pseudo-random sequence. Three counters record load hits, load misses and cycles lost to a full store queue, for performance measurement.

Addresses on every port are word addresses. The word offset is bits [1:0], the set index is bits [7:2] and the tag is bits [29:8].

Top module: `dcache_top`

## Requirements
- R1: While reset is held and after it is released, the following outputs are low: both stalls, `respValid` and `memReq`. All three counters read zero.
- R2: A load accepted in one cycle that hits returns its word on `respData` with `respValid` high in the next cycle, with no stall, and `loadHits` grows by one.
- R3: A load that misses raises `stallMe2` in the cycle after it was accepted, and `loadMisses` grows by one. The word is returned with `respValid` in the first cycle in which `stallMe2` is low again.
- R4: A refill issues its first read only after every earlier store has been written to memory. It then reads the four words of the missing line in ascending word-address order (offset 0 to 3).
- R5: If a set has an invalid way, the refill uses it. Two lines with different tags in the same set can therefore both be resident, and both then hit.
- R6: When both ways are valid, the victim way is picked at random. Over repeated trials, each of the two resident lines is sometimes the one evicted.
- R7: A store that hits updates the cached word. A later load of that word hits and returns the new value, and the store also appears as a write on the memory port.
- R8: A store that misses does not allocate a line. A later load of that address misses.
- R9: The store queue holds four entries. A store presented while it is full raises `stallMe1` in that same cycle and is not accepted. `wbStallCycles` counts every such cycle.
- R10: Stalls hold the stage registers. Every accepted load produces exactly one response, in order, and every accepted store produces exactly one memory write.
- R11: A memory request keeps its address, direction and data unchanged until it is acknowledged.
- R12: A load always returns the most recent value stored to that word in program order, even when that store is still queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access present in the first memory stage |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWordAddr | input | 30 | Word address of the access |
| reqWdata | input | 32 | Store data |
| stallMe1 | output | 1 | First-stage stall: store queue full |
| stallMe2 | output | 1 | Second-stage stall: load miss in progress |
| respValid | output | 1 | Load data valid |
| respData | output | 32 | Load data |
| memReq | output | 1 | Memory request pending |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 30 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Request completed this cycle |
| loadHits | output | 32 | Load hit count |
| loadMisses | output | 32 | Load miss count |
| wbStallCycles | output | 32 | Cycles stalled on a full store queue |

## Verification
A wrong tag, a wrong valid bit or wrong line data shows up as a stale or wrong `respData` on the very next load of that word. It also shows up as a hit/miss count that differs from the expected residency. A broken store queue shows up as lost or repeated writes on the memory port, or as a refill read that overtakes a queued store. A broken stall interaction shows up within one cycle as a missing, duplicated or misordered response.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_DRAIN,
    FS_FILL,
    FS_DONE
  } fillState_t;

  typedef struct packed {
    logic accept;
    logic missStart;
    logic fillActive;
    logic fillWe;
    logic fillLast;
    logic hitResp;
    logic fillResp;
    logic storeHit;
  } ctrlStrobe_t;
endpackage

// File: rtl/dcache_wbuf.sv
module dcache_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [AW-1:0] pushAddr,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headAddr = addrQ[rdPtr];
  assign headData = dataQ[rdPtr];

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN) push |-> !full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             wbFull,
  input  logic             wbEmpty,
  input  logic             me2Valid,
  input  logic             me2Write,
  input  logic             me2Hit,
  input  logic             memAck,
  output logic             stallMe1,
  output logic             stallMe2,
  output logic [OFF_W-1:0] fillWord,
  output ctrlStrobe_t      stb
);
  localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'(LINE_WORDS - 1);

  fillState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    stallMe2  = 1'b0;
    unique case (state)
      FS_IDLE: begin
        if (me2Valid && !me2Write) begin
          if (me2Hit) begin
            stb.hitResp = 1'b1;
          end else begin
            stallMe2      = 1'b1;
            stb.missStart = 1'b1;
            nextState     = FS_DRAIN;
          end
        end else if (me2Valid && me2Write && me2Hit) begin
          stb.storeHit = 1'b1;
        end
      end
      FS_DRAIN: begin
        stallMe2 = 1'b1;
        if (wbEmpty) nextState = FS_FILL;
      end
      FS_FILL: begin
        stallMe2       = 1'b1;
        stb.fillActive = 1'b1;
        if (memAck) begin
          stb.fillWe = 1'b1;
          if (fillWord == WORD_LAST) begin
            stb.fillLast = 1'b1;
            nextState    = FS_DONE;
          end
        end
      end
      FS_DONE: begin
        stb.fillResp = 1'b1;
        nextState    = FS_IDLE;
      end
      default: nextState = FS_IDLE;
    endcase
    stallMe1   = reqValid && reqWrite && wbFull;
    stb.accept = reqValid && !stallMe1 && !stallMe2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= FS_IDLE;
      fillWord <= '0;
    end else begin
      state <= nextState;
      if (state == FS_DRAIN)  fillWord <= '0;
      else if (stb.fillWe)    fillWord <= fillWord + 1'b1;
    end
  end

  // R4
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillActive |-> wbEmpty);
  // R3
  miss_stall_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallMe2 |-> (me2Valid && !me2Write));
endmodule

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int WB_DEPTH   = 4,
  parameter int CNT_W      = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic [WA_W-1:0]   reqWordAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  ctrlStrobe_t       stb,
  input  logic [OFF_W-1:0]  fillWord,
  input  logic              stallMe1,
  input  logic              stallMe2,
  output logic              me2Valid,
  output logic              me2Write,
  output logic              me2Hit,
  output logic              wbFull,
  output logic              wbEmpty,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic              memWe,
  output logic [WA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [CNT_W-1:0]  loadHits,
  output logic [CNT_W-1:0]  loadMisses,
  output logic [CNT_W-1:0]  wbStallCycles
);
  localparam int TAG_W = WA_W - IDX_W - OFF_W;
  localparam int LOC_W = IDX_W + OFF_W;
  localparam int LINES_WORDS_TOTAL = SETS * LINE_WORDS;
  localparam int LFSR_W = 16;

  // second-stage register
  logic [WA_W-1:0]   me2Addr;
  logic [DATA_W-1:0] me2Data;

  logic [TAG_W-1:0] reqTag, me2Tag;
  logic [IDX_W-1:0] reqIdx, me2Idx;
  logic [OFF_W-1:0] reqOff, me2Off;

  assign reqOff = reqWordAddr[OFF_W-1:0];
  assign reqIdx = reqWordAddr[OFF_W +: IDX_W];
  assign reqTag = reqWordAddr[WA_W-1 -: TAG_W];
  assign me2Off = me2Addr[OFF_W-1:0];
  assign me2Idx = me2Addr[OFF_W +: IDX_W];
  assign me2Tag = me2Addr[WA_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      me2Valid <= 1'b0;
      me2Write <= 1'b0;
    end else if (!stallMe2) begin
      me2Valid <= stb.accept;
      if (stb.accept) me2Write <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.accept) begin
      me2Addr <= reqWordAddr;
      me2Data <= reqWdata;
    end
  end

  // array write port shared by refill and store hit
  logic [LOC_W-1:0]  rdLoc, dWaddr;
  logic [DATA_W-1:0] dWdata;
  logic [WAYS-1:0]   dWe, tWe, hitVec, rdValidV;
  logic [WAYS-1:0][DATA_W-1:0] rdDataV;
  logic [WAYS-1:0][TAG_W-1:0]  rdTagV;
  logic victim;

  assign rdLoc  = {reqIdx, reqOff};
  assign dWaddr = stb.fillActive ? {me2Idx, fillWord} : {me2Idx, me2Off};
  assign dWdata = stb.fillActive ? memRdata : me2Data;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] dArr [LINES_WORDS_TOTAL];
    logic [TAG_W-1:0]  tArr [SETS];
    logic [SETS-1:0]   vBits;
    logic [DATA_W-1:0] dOut;
    logic [TAG_W-1:0]  tOut;
    logic              vOut;

    assign dWe[w] = (stb.fillWe && (victim == 1'(w))) || (stb.storeHit && hitVec[w]);
    assign tWe[w] = stb.fillLast && (victim == 1'(w));

    always_ff @(posedge clk) begin
      if (dWe[w]) dArr[dWaddr] <= dWdata;
      if (stb.accept) dOut <= (dWe[w] && (dWaddr == rdLoc)) ? dWdata : dArr[rdLoc];
    end

    always_ff @(posedge clk) begin
      if (tWe[w]) tArr[me2Idx] <= me2Tag;
      if (stb.accept) tOut <= (tWe[w] && (me2Idx == reqIdx)) ? me2Tag : tArr[reqIdx];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vBits <= '0;
        vOut  <= 1'b0;
      end else begin
        if (tWe[w]) vBits[me2Idx] <= 1'b1;
        if (stb.accept) vOut <= (tWe[w] && (me2Idx == reqIdx)) || vBits[reqIdx];
      end
    end

    assign rdDataV[w]  = dOut;
    assign rdTagV[w]   = tOut;
    assign rdValidV[w] = vOut;
    assign hitVec[w]   = vOut && (tOut == me2Tag);
  end

  assign me2Hit = |hitVec;

  logic [DATA_W-1:0] hitData;
  always_comb begin
    hitData = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitData = rdDataV[w];
    end
  end

  // replacement: invalid way first, otherwise pseudo-random
  logic [LFSR_W-1:0] lfsr;
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  logic [DATA_W-1:0] fillData;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      victim <= 1'b0;
    end else if (stb.missStart) begin
      victim <= !rdValidV[0] ? 1'b0 : (!rdValidV[1] ? 1'b1 : lfsr[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillWe && (fillWord == me2Off)) fillData <= memRdata;
  end

  assign respValid = stb.hitResp || stb.fillResp;
  assign respData  = stb.fillResp ? fillData : hitData;

  // store queue and memory port
  logic [WA_W-1:0]   wbHeadAddr;
  logic [DATA_W-1:0] wbHeadData;
  logic              wbPop;

  assign wbPop = memAck && !stb.fillActive;

  dcache_wbuf #(.DEPTH(WB_DEPTH), .AW(WA_W), .DW(DATA_W)) u_wbuf (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.accept && reqWrite),
    .pushAddr (reqWordAddr),
    .pushData (reqWdata),
    .pop      (wbPop),
    .headAddr (wbHeadAddr),
    .headData (wbHeadData),
    .empty    (wbEmpty),
    .full     (wbFull)
  );

  assign memReq   = stb.fillActive || !wbEmpty;
  assign memWe    = !stb.fillActive && !wbEmpty;
  assign memAddr  = stb.fillActive ? {me2Tag, me2Idx, fillWord} : wbHeadAddr;
  assign memWdata = wbHeadData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadHits      <= '0;
      loadMisses    <= '0;
      wbStallCycles <= '0;
    end else begin
      if (stb.hitResp)   loadHits      <= loadHits + 1'b1;
      if (stb.missStart) loadMisses    <= loadMisses + 1'b1;
      if (stallMe1)      wbStallCycles <= wbStallCycles + 1'b1;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));
  // R10
  me2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallMe2 |=> ($stable(me2Addr) && me2Valid));
  // R5
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    me2Valid |-> $onehot0(hitVec));
endmodule

// File: rtl/dcache_top.sv
module dcache_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int WB_DEPTH   = 4,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-3:0] reqWordAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              stallMe1,
  output logic              stallMe2,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-3:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [CNT_W-1:0]  loadHits,
  output logic [CNT_W-1:0]  loadMisses,
  output logic [CNT_W-1:0]  wbStallCycles
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  ctrlStrobe_t      stb;
  logic [OFF_W-1:0] fillWord;
  logic me2Valid, me2Write, me2Hit, wbFull, wbEmpty;

  dcache_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .wbFull   (wbFull),
    .wbEmpty  (wbEmpty),
    .me2Valid (me2Valid),
    .me2Write (me2Write),
    .me2Hit   (me2Hit),
    .memAck   (memAck),
    .stallMe1 (stallMe1),
    .stallMe2 (stallMe2),
    .fillWord (fillWord),
    .stb      (stb)
  );

  dcache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS),
    .LINE_WORDS(LINE_WORDS), .WB_DEPTH(WB_DEPTH), .CNT_W(CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .reqWrite      (reqWrite),
    .reqWordAddr   (reqWordAddr),
    .reqWdata      (reqWdata),
    .stb           (stb),
    .fillWord      (fillWord),
    .stallMe1      (stallMe1),
    .stallMe2      (stallMe2),
    .me2Valid      (me2Valid),
    .me2Write      (me2Write),
    .me2Hit        (me2Hit),
    .wbFull        (wbFull),
    .wbEmpty       (wbEmpty),
    .respValid     (respValid),
    .respData      (respData),
    .memReq        (memReq),
    .memWe         (memWe),
    .memAddr       (memAddr),
    .memWdata      (memWdata),
    .memRdata      (memRdata),
    .memAck        (memAck),
    .loadHits      (loadHits),
    .loadMisses    (loadMisses),
    .wbStallCycles (wbStallCycles)
  );

  // R2
  load_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !stallMe1 && !stallMe2) |=> (respValid || stallMe2));
  // R10
  resp_not_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !stallMe2);
endmodule

// File: tb/dcache_top_bench.sv
module dcache_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [29:0] reqWordAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        stallMe1, stallMe2, respValid, memReq, memWe;
  logic [31:0] respData, memWdata;
  logic [29:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [31:0] loadHits, loadMisses, wbStallCycles;

  dcache_top u_dcache_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWordAddr(reqWordAddr), .reqWdata(reqWdata), .stallMe1(stallMe1),
    .stallMe2(stallMe2), .respValid(respValid), .respData(respData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .loadHits(loadHits),
    .loadMisses(loadMisses), .wbStallCycles(wbStallCycles)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int loadsIssued = 0, storesIssued = 0, respsSeen = 0, memWrites = 0;
  int stall1Cycles = 0, orderBad = 0, slowMem = 0, latCnt = 0;
  logic [31:0] refMem [int unsigned];
  logic [31:0] bkMem  [int unsigned];
  logic [31:0] expQ [$];
  int unsigned readLog [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] initWord(input int unsigned wa);
    return (wa * 32'h2545F491) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] refRead(input int unsigned wa);
    return refMem.exists(wa) ? refMem[wa] : initWord(wa);
  endfunction

  function automatic logic [31:0] bkRead(input int unsigned wa);
    return bkMem.exists(wa) ? bkMem[wa] : initWord(wa);
  endfunction

  function automatic logic [29:0] wa(input int tag, input int idx, input int off);
    return {22'(tag), 6'(idx), 2'(off)};
  endfunction

  // backing memory
  always @(negedge clk) begin
    memAck = 1'b0;
    if (rstN && memReq) begin
      if (latCnt == 0) begin
        memAck = 1'b1;
        if (memWe) begin
          bkMem[memAddr] = memWdata;
          memWrites++;
        end else begin
          if (memWrites != storesIssued) orderBad++;
          memRdata = bkRead(memAddr);
          readLog.push_back(memAddr);
        end
        latCnt = (slowMem != 0) ? 10 : $urandom_range(0, 2);
      end else begin
        latCnt--;
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (stallMe1) stall1Cycles++;
      if (respValid) begin
        respsSeen++;
        if (expQ.size() == 0) chk(1'b0, "R10", "unexpected response", respData, 0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk(respData == e, "R12", "load data", respData, e);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [29:0] a, input logic [31:0] d);
    bit acc;
    reqValid = 1'b1; reqWrite = wr; reqWordAddr = a; reqWdata = d;
    do begin
      #1;
      acc = !stallMe1 && !stallMe2;
      if (acc) begin
        if (wr) begin refMem[a] = d; storesIssued++; end
        else begin expQ.push_back(refRead(a)); loadsIssued++; end
      end
      @(negedge clk);
    end while (!acc);
    reqValid = 1'b0;
  endtask

  task automatic quiesce();
    reqValid = 1'b0;
    do begin
      @(negedge clk);
      #2;
    end while (expQ.size() != 0 || memReq || stallMe2);
  endtask

  task automatic probe(input logic [29:0] a, output bit wasHit);
    logic [31:0] h0, m0;
    h0 = loadHits; m0 = loadMisses;
    access(1'b0, a, '0);
    quiesce();
    wasHit = (loadHits != h0);
    chk((loadHits - h0) + (loadMisses - m0) == 1, "R10", "one count per load",
        (loadHits - h0) + (loadMisses - m0), 1);
  endtask

  task automatic expectLoad(input logic [29:0] a, input bit expHit, input string req);
    bit h;
    probe(a, h);
    chk(h == expHit, req, "hit outcome", h, expHit);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit h;
    int aHits;
    void'($urandom(7));
    repeat (4) @(negedge clk);
    #1;
    chk(!stallMe1 && !stallMe2 && !respValid && !memReq, "R1", "outputs in reset",
        {stallMe1, stallMe2, respValid, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!stallMe1 && !stallMe2 && !respValid && !memReq, "R1", "outputs after reset",
        {stallMe1, stallMe2, respValid, memReq}, 0);
    chk(loadHits == 0 && loadMisses == 0 && wbStallCycles == 0, "R1", "counters",
        loadHits + loadMisses + wbStallCycles, 0);
    @(negedge clk);

    // R3 miss timing, R4 refill order
    readLog.delete();
    access(1'b0, wa(1, 5, 2), '0);
    #1;
    chk(stallMe2 == 1'b1, "R3", "stall after miss", stallMe2, 1);
    quiesce();
    chk(loadMisses == 1, "R3", "miss count", loadMisses, 1);
    chk(readLog.size() == 4, "R4", "refill read count", readLog.size(), 4);
    for (int i = 0; i < 4 && i < readLog.size(); i++)
      chk(readLog[i] == wa(1, 5, i), "R4", "refill order", readLog[i], wa(1, 5, i));

    // R2 hit timing
    @(negedge clk);
    access(1'b0, wa(1, 5, 3), '0);
    #1;
    chk(respValid && !stallMe2, "R2", "hit response next cycle", {respValid, stallMe2}, 2);
    quiesce();
    chk(loadHits == 1, "R2", "hit count", loadHits, 1);

    // R5 invalid way first
    expectLoad(wa(2, 5, 0), 1'b0, "R5");
    expectLoad(wa(1, 5, 1), 1'b1, "R5");
    expectLoad(wa(2, 5, 1), 1'b1, "R5");

    // R7 store hit, R12 store then load
    access(1'b1, wa(1, 5, 1), 32'hCAFE0001);
    expectLoad(wa(1, 5, 1), 1'b1, "R7");
    chk(bkRead(wa(1, 5, 1)) == 32'hCAFE0001, "R7", "write-through", bkRead(wa(1, 5, 1)), 32'hCAFE0001);

    // R8 store miss no allocate
    access(1'b1, wa(9, 12, 0), 32'h0BAD0BAD);
    quiesce();
    expectLoad(wa(9, 12, 0), 1'b0, "R8");

    // R4 refill waits for queued stores
    access(1'b1, wa(3, 20, 0), 32'h11111111);
    access(1'b1, wa(3, 21, 0), 32'h22222222);
    access(1'b1, wa(3, 22, 0), 32'h33333333);
    expectLoad(wa(3, 22, 0), 1'b0, "R4");

    // R9 full store queue
    slowMem = 1;
    for (int i = 0; i < 7; i++) access(1'b1, wa(4, 30 + i, 0), 32'hA0000000 + i);
    quiesce();
    slowMem = 0;
    chk(stall1Cycles > 0, "R9", "first-stage stall seen", stall1Cycles, 1);
    chk(wbStallCycles == stall1Cycles, "R9", "stall counter", wbStallCycles, stall1Cycles);

    // R6 random victim
    aHits = 0;
    for (int s = 0; s < 16; s++) begin
      expectLoad(wa(100, 40 + s, 0), 1'b0, "R6");
      expectLoad(wa(101, 40 + s, 0), 1'b0, "R6");
      expectLoad(wa(102, 40 + s, 0), 1'b0, "R6");
      expectLoad(wa(102, 40 + s, 1), 1'b1, "R6");
      probe(wa(100, 40 + s, 0), h);
      if (h) begin
        aHits++;
        expectLoad(wa(101, 40 + s, 0), 1'b0, "R6");
      end
    end
    chk(aHits > 0 && aHits < 16, "R6", "both ways evicted", aHits, 8);

    // random mix, R10 and R12
    for (int n = 0; n < 2000; n++) begin
      int t, ix, of;
      t = 200 + $urandom_range(0, 3);
      ix = $urandom_range(0, 3);
      of = $urandom_range(0, 3);
      access($urandom_range(0, 2) == 0, wa(t, ix, of), $urandom);
      if ($urandom_range(0, 9) == 0) @(negedge clk);
    end
    quiesce();

    chk(respsSeen == loadsIssued, "R10", "responses per load", respsSeen, loadsIssued);
    chk(memWrites == storesIssued, "R10", "writes per store", memWrites, storesIssued);
    chk(loadHits + loadMisses == loadsIssued, "R10", "hit+miss count",
        loadHits + loadMisses, loadsIssued);
    chk(orderBad == 0, "R4", "refill read before store drain", orderBad, 0);
    chk(wbStallCycles == stall1Cycles, "R9", "final stall counter", wbStallCycles, stall1Cycles);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule